// File: doc/BRIEF.md
# Field Memory Power-Up Initialiser

This block sits between the traffic controller of a dual-port serial field memory and the memory's control pins, and puts the memory into a known state after power-up. The memory's write and read address pointers hold no valid value until they have been clocked and reset. The block first waits until the supply has been reported stable for a programmable interval. It then clocks both ports through a run of dummy cycles and ends each port with a one-clock pointer reset. During the dummy writes the write enable is high and the input gate is low, so no memory content is changed. During the dummy reads the output gate is held low.

Each memory port is described by four control lines, all sampled on `clk`:
- a cycle strobe: one port clock is issued for each `clk` cycle in which it is high;
- an enable: the pointer advances;
- a data gate: write commit on the write port, output drive on the read port;
- a pointer reset.

When `slow_start` is high on the cycle the wait ends, the block runs a recovery recipe on each port instead: reset, a burst of dummy cycles, reset. This recipe is for a start in which dummy cycling may have begun before the supply settled. Both ports run in lockstep. Once both have finished, `init_done` rises and the external controls pass straight through to the memory.

Top module: `fmi_init`

## Requirements
- R1: While `rst_n` is low, every `mem_*` output and `init_done` are low.
- R2: With W = ceil(STAB_US*1000/CLK_PERIOD_NS), the first dummy cycle strobe appears after the (W+1)th consecutive rising `clk` edge at which `supply_ok` is high. No strobe, enable or reset reaches the memory before that.
- R3: Each port receives exactly DUMMY_CYCLES cycles with strobe and enable high and reset low. The strobe stays high on every cycle from the first dummy cycle to the last cycle of the port's sequence: 1+DUMMY_CYCLES+RST_GAP cycles in the normal recipe, 2+DUMMY_CYCLES+2*RST_GAP in the recovery recipe.
- R4: The write data gate and the read output gate stay low until `init_done` is high.
- R5: Every reset pulse lasts exactly one cycle. At least RST_GAP (≥2) low cycles of the strobed port separate a reset pulse from the next pulse, and from `init_done`.
- R6: In the normal recipe (`slow_start` low when the wait ends), each port issues all its dummy cycles and then exactly one reset.
- R7: In the recovery recipe (`slow_start` high when the wait ends), each port issues a reset, then RST_GAP strobe-only cycles, then the dummy cycles, then a second reset. `slow_start` is sampled only in the cycle the wait ends.
- R8: A low `supply_ok` at any rising edge during the wait restarts the stability count from zero.
- R9: Before `init_done`, both ports start on the same cycle and their strobe and reset lines are identical on every cycle.
- R10: Let f be the cycle of the first dummy strobe. `init_done` rises at cycle f+DUMMY_CYCLES+RST_GAP+2 in the normal recipe and at f+DUMMY_CYCLES+2*RST_GAP+3 in the recovery recipe. It stays high until reset.
- R11: Before `init_done` the `ext_*` inputs have no effect on the `mem_*` outputs. Once `init_done` is high, each `mem_*` output equals its `ext_*` counterpart in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one memory port cycle per strobed clk cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok | input | 1 | High while the supply is within its operating range |
| slow_start | input | 1 | Selects the recovery recipe when sampled at the end of the wait |
| ext_wr_cyc | input | 1 | Controller write-port cycle strobe |
| ext_wr_en | input | 1 | Controller write pointer enable |
| ext_wr_in_en | input | 1 | Controller write data gate |
| ext_wr_rst | input | 1 | Controller write pointer reset |
| ext_rd_cyc | input | 1 | Controller read-port cycle strobe |
| ext_rd_en | input | 1 | Controller read pointer enable |
| ext_rd_out_en | input | 1 | Controller read output gate |
| ext_rd_rst | input | 1 | Controller read pointer reset |
| mem_wr_cyc | output | 1 | Write-port cycle strobe to memory |
| mem_wr_en | output | 1 | Write pointer enable to memory |
| mem_wr_in_en | output | 1 | Write data gate to memory |
| mem_wr_rst | output | 1 | Write pointer reset to memory |
| mem_rd_cyc | output | 1 | Read-port cycle strobe to memory |
| mem_rd_en | output | 1 | Read pointer enable to memory |
| mem_rd_out_en | output | 1 | Read output gate to memory |
| mem_rd_rst | output | 1 | Read pointer reset to memory |
| init_done | output | 1 | High once both port sequences have finished |

## Verification
The assertions assume the following about the inputs:
- `supply_ok` stays high from the end of the wait until `init_done`;
- `slow_start` only matters on the cycle the wait ends;
- RST_GAP is at least 2.

The stimulus stays within these limits. Supply glitches are driven only while the stability count is below its limit. `slow_start` is fixed per run and flipped only after the sequence has started. The `ext_*` lines, by contrast, toggle at random on every cycle, including during initialisation, so that any leak of them through the mux is caught.

// File: rtl/fmi_pkg.sv
package fmi_pkg;

    typedef struct packed {
        logic cyc;
        logic en;
        logic gate;
        logic rst;
    } port_ctl_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE_RST,
        S_PRE_GAP,
        S_BURST,
        S_FIN_RST,
        S_FIN_GAP,
        S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        T_WAIT,
        T_RUN,
        T_READY
    } top_state_e;

endpackage

// File: rtl/fmi_stab_timer.sv
module fmi_stab_timer #(
    parameter int WAIT_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    output logic stable
);
    localparam int CW = $clog2(WAIT_CYC + 1);
    localparam logic [CW-1:0] WAIT_V = CW'(WAIT_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!supply_ok) begin
            cnt_d = '0;
        end else if (cnt_q != WAIT_V) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign stable = (cnt_q == WAIT_V);

    // R8: a low supply sample restarts the count
    a_r8_drop_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !stable);

endmodule

// File: rtl/fmi_port_seq.sv
module fmi_port_seq
    import fmi_pkg::*;
#(
    parameter int DUMMY_CYCLES = 80,
    parameter int RST_GAP      = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      recover,
    output port_ctl_t ctl,
    output logic      done
);
    localparam int CNT_MAX = (DUMMY_CYCLES > RST_GAP) ? DUMMY_CYCLES : RST_GAP;
    localparam int CW = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] BURST_LAST = CW'(DUMMY_CYCLES - 1);
    localparam logic [CW-1:0] GAP_LAST   = CW'(RST_GAP - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.st  = recover ? S_PRE_RST : S_BURST;
                    r_d.cnt = '0;
                end
            end
            S_PRE_RST: begin
                r_d.st  = S_PRE_GAP;
                r_d.cnt = '0;
            end
            S_PRE_GAP: begin
                if (r_q.cnt == GAP_LAST) begin
                    r_d.st  = S_BURST;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            S_BURST: begin
                if (r_q.cnt == BURST_LAST) begin
                    r_d.st  = S_FIN_RST;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            S_FIN_RST: begin
                r_d.st  = S_FIN_GAP;
                r_d.cnt = '0;
            end
            S_FIN_GAP: begin
                if (r_q.cnt == GAP_LAST) begin
                    r_d.st  = S_DONE;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= S_IDLE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        ctl.cyc  = (r_q.st != S_IDLE) && (r_q.st != S_DONE);
        ctl.en   = (r_q.st == S_BURST);
        ctl.gate = 1'b0;
        ctl.rst  = (r_q.st == S_PRE_RST) || (r_q.st == S_FIN_RST);
        done     = (r_q.st == S_DONE);
    end

    // R5: one-cycle reset pulses followed by at least two low cycles
    a_r5_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.rst |=> !ctl.rst);
    a_r5_two_low_after: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl.rst) |=> !ctl.rst);
    // R3: a dummy burst always ends in a pointer reset
    a_r3_burst_then_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl.en) |-> ctl.rst);
    // R10: completion is sticky
    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

endmodule

// File: rtl/fmi_init.sv
module fmi_init
    import fmi_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter int STAB_US       = 100,
    parameter int DUMMY_CYCLES  = 80,
    parameter int RST_GAP       = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic slow_start,
    input  logic ext_wr_cyc,
    input  logic ext_wr_en,
    input  logic ext_wr_in_en,
    input  logic ext_wr_rst,
    input  logic ext_rd_cyc,
    input  logic ext_rd_en,
    input  logic ext_rd_out_en,
    input  logic ext_rd_rst,
    output logic mem_wr_cyc,
    output logic mem_wr_en,
    output logic mem_wr_in_en,
    output logic mem_wr_rst,
    output logic mem_rd_cyc,
    output logic mem_rd_en,
    output logic mem_rd_out_en,
    output logic mem_rd_rst,
    output logic init_done
);
    localparam int WAIT_CYC = (STAB_US * 1000 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int NPORT    = 2;

    top_state_e st_d, st_q;
    logic       stable;
    logic       start;
    port_ctl_t  ext_c [NPORT];
    port_ctl_t  seq_c [NPORT];
    port_ctl_t  out_c [NPORT];
    logic [NPORT-1:0] port_done;

    fmi_stab_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .stable    (stable)
    );

    assign start = (st_q == T_WAIT) && stable;

    always_comb begin
        ext_c[0] = '{cyc: ext_wr_cyc, en: ext_wr_en, gate: ext_wr_in_en, rst: ext_wr_rst};
        ext_c[1] = '{cyc: ext_rd_cyc, en: ext_rd_en, gate: ext_rd_out_en, rst: ext_rd_rst};
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        fmi_port_seq #(
            .DUMMY_CYCLES (DUMMY_CYCLES),
            .RST_GAP      (RST_GAP)
        ) u_seq (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (start),
            .recover (slow_start),
            .ctl     (seq_c[p]),
            .done    (port_done[p])
        );
        assign out_c[p] = init_done ? ext_c[p] : seq_c[p];
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            T_WAIT:  if (stable)     st_d = T_RUN;
            T_RUN:   if (&port_done) st_d = T_READY;
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= T_WAIT;
        else        st_q <= st_d;
    end

    assign init_done = (st_q == T_READY);

    always_comb begin
        {mem_wr_cyc, mem_wr_en, mem_wr_in_en, mem_wr_rst} = out_c[0];
        {mem_rd_cyc, mem_rd_en, mem_rd_out_en, mem_rd_rst} = out_c[1];
    end

    // R2: nothing reaches the memory while the wait runs
    a_r2_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == T_WAIT) |-> !(mem_wr_cyc || mem_rd_cyc || mem_wr_rst || mem_rd_rst));
    // R4: data gates stay closed during initialisation
    a_r4_gates_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !(mem_wr_in_en || mem_rd_out_en));
    // R9: both ports in lockstep before completion
    a_r9_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> (mem_wr_cyc == mem_rd_cyc) && (mem_wr_rst == mem_rd_rst));
    // R10: completion follows both port sequences
    a_r10_done_after_ports: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(&port_done));

endmodule

// File: tb/sim_fmi_init.sv
module sim_fmi_init;
    localparam int CLK_NS = 20;
    localparam int STAB   = 2;
    localparam int DUMMY  = 80;
    localparam int GAP    = 2;
    localparam int W      = (STAB * 1000 + CLK_NS - 1) / CLK_NS;

    logic clk = 1'b0;
    logic rst_n, supply_ok, slow_start;
    logic e_wc, e_we, e_wg, e_wr, e_rc, e_re, e_rg, e_rr;
    logic m_wc, m_we, m_wg, m_wr, m_rc, m_re, m_rg, m_rr;
    logic init_done;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_NS / 2) clk = ~clk;

    fmi_init #(
        .CLK_PERIOD_NS (CLK_NS),
        .STAB_US       (STAB),
        .DUMMY_CYCLES  (DUMMY),
        .RST_GAP       (GAP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .slow_start(slow_start),
        .ext_wr_cyc(e_wc), .ext_wr_en(e_we), .ext_wr_in_en(e_wg), .ext_wr_rst(e_wr),
        .ext_rd_cyc(e_rc), .ext_rd_en(e_re), .ext_rd_out_en(e_rg), .ext_rd_rst(e_rr),
        .mem_wr_cyc(m_wc), .mem_wr_en(m_we), .mem_wr_in_en(m_wg), .mem_wr_rst(m_wr),
        .mem_rd_cyc(m_rc), .mem_rd_en(m_re), .mem_rd_out_en(m_rg), .mem_rd_rst(m_rr),
        .init_done(init_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_done_off(input bit rec);
        return (rec ? GAP + 1 : 0) + DUMMY + GAP + 2;
    endfunction

    function automatic int exp_cyc_len(input bit rec);
        return rec ? 2 + DUMMY + 2 * GAP : 1 + DUMMY + GAP;
    endfunction

    task automatic drive_ext();
        {e_wc, e_we, e_wg, e_wr, e_rc, e_re, e_rg, e_rr} = 8'($urandom);
    endtask

    task automatic run_case(input bit rec, input bit glitch);
        int hi, t, done_at, gat, gate_bad, lock_bad, wid_bad, gap_bad;
        bit done_seen, glitched;
        int first[2], hi_first[2], cyc_cnt[2], en_cnt[2], en_before[2];
        int rst_cnt[2], last_rst[2], early[2];
        bit prev_rst[2];
        logic [3:0] o[2];
        rst_n = 1'b0; supply_ok = 1'b0; slow_start = rec; drive_ext();
        repeat (3) @(negedge clk);
        check({m_wc, m_we, m_wg, m_wr, m_rc, m_re, m_rg, m_rr, init_done} == 9'd0,
              "R1 reset state", int'({m_wc, m_wr, m_rc, m_rr, init_done}), 0);
        rst_n = 1'b1;
        repeat (1 + $urandom_range(4)) begin @(negedge clk); drive_ext(); end
        supply_ok = 1'b1;
        hi = 0; done_seen = 0; glitched = 0; done_at = -1;
        gat = 1 + $urandom_range(W - 2);
        gate_bad = 0; lock_bad = 0; wid_bad = 0; gap_bad = 0;
        for (int p = 0; p < 2; p++) begin
            first[p] = -1; hi_first[p] = -1; cyc_cnt[p] = 0; en_cnt[p] = 0;
            en_before[p] = -1; rst_cnt[p] = 0; last_rst[p] = -1000;
            early[p] = 0; prev_rst[p] = 0;
        end
        t = 0;
        while (!done_seen && t < 4 * W + 4 * DUMMY) begin
            @(negedge clk);
            if (supply_ok) hi++; else hi = 0;
            if (init_done) begin
                done_seen = 1; done_at = t;
            end else begin
                o[0] = {m_wc, m_we, m_wg, m_wr};
                o[1] = {m_rc, m_re, m_rg, m_rr};
                if (o[0][3] != o[1][3] || o[0][0] != o[1][0]) lock_bad++;
                for (int p = 0; p < 2; p++) begin
                    if (o[p][3] && first[p] < 0) begin first[p] = t; hi_first[p] = hi; end
                    if (first[p] < 0 && (o[p][2] || o[p][0])) early[p]++;
                    if (o[p][3]) cyc_cnt[p]++;
                    if (o[p][1]) gate_bad++;
                    if (o[p][2] && !o[p][0]) en_cnt[p]++;
                    if (o[p][0]) begin
                        if (prev_rst[p]) wid_bad++;
                        else if (t - last_rst[p] < GAP + 1) gap_bad++;
                        rst_cnt[p]++;
                        if (rst_cnt[p] == 1) en_before[p] = en_cnt[p];
                        last_rst[p] = t;
                    end
                    prev_rst[p] = o[p][0];
                end
                if (first[0] >= 0) slow_start = !rec;
            end
            if (!supply_ok) supply_ok = 1'b1;
            else if (glitch && !glitched && hi == gat) begin supply_ok = 1'b0; glitched = 1; end
            drive_ext();
            t++;
        end
        check(done_seen, "R10 done reached", int'(done_seen), 1);
        for (int p = 0; p < 2; p++) begin
            check(hi_first[p] == W + 1, glitch ? "R8 restart / R2 wait length" : "R2 wait length",
                  hi_first[p], W + 1);
            check(early[p] == 0, "R2 nothing before start", early[p], 0);
            check(cyc_cnt[p] == exp_cyc_len(rec), "R3 strobe run", cyc_cnt[p], exp_cyc_len(rec));
            check(en_cnt[p] == DUMMY, "R3 dummy count", en_cnt[p], DUMMY);
            check(rst_cnt[p] == (rec ? 2 : 1), rec ? "R7 reset count" : "R6 reset count",
                  rst_cnt[p], rec ? 2 : 1);
            check(en_before[p] == (rec ? 0 : DUMMY), rec ? "R7 order" : "R6 order",
                  en_before[p], rec ? 0 : DUMMY);
            check(done_at - last_rst[p] >= GAP + 1, "R5 gap before done",
                  done_at - last_rst[p], GAP + 1);
        end
        check(wid_bad == 0 && gap_bad == 0, "R5 pulse width and gap", wid_bad + gap_bad, 0);
        check(gate_bad == 0, "R4 gates closed", gate_bad, 0);
        check(first[0] == first[1] && lock_bad == 0, "R9 lockstep", lock_bad, 0);
        check(done_at == first[0] + exp_done_off(rec), "R10 done cycle",
              done_at - first[0], exp_done_off(rec));
        begin
            int pt_bad = 0;
            repeat (16) begin
                @(negedge clk); drive_ext(); #1;
                if ({m_wc, m_we, m_wg, m_wr, m_rc, m_re, m_rg, m_rr} !=
                    {e_wc, e_we, e_wg, e_wr, e_rc, e_re, e_rg, e_rr} || !init_done) pt_bad++;
            end
            check(pt_bad == 0, "R11 pass-through", pt_bad, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7319));
        run_case(1'b0, 1'b0);
        run_case(1'b1, 1'b0);
        run_case(1'b0, 1'b1);
        run_case(1'b1, 1'b1);
        for (int k = 0; k < 4; k++) run_case(1'($urandom), 1'($urandom));
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule